// File: doc/BRIEF.md
# Product-term cluster allocator

This block is the sum-of-products core of one logic block in a programmable logic device. It takes 22 routed input signals and forms 68 product terms. Each term is the AND of any chosen set of true or complemented inputs. Sixty-four of the terms are logic terms, grouped into 16 clusters of four. A static steering word sends each cluster to one macrocell chosen from a small sliding window of nearby macrocells, or leaves the cluster unused. Each of the 16 macrocell sums is the OR of every cluster steered to it. A macrocell can therefore build a sum as wide as 16 terms, but only by taking clusters from its neighbours.

The remaining four terms are special-purpose terms. Two serve as output-enable terms, one as an asynchronous reset term and one as an asynchronous preset term. They bypass the steering logic. All outputs are registered once, so the downstream macrocell logic sees stable values. Configuration is loaded statically and is held on input ports.

Top module: `pterm_alloc`

## Requirements
- R1: Each term has 2 configuration bits per input j. Bit 2j requires in_vec[j]=1 and bit 2j+1 requires in_vec[j]=0. The term is the AND of all required literals. A term with no bit set evaluates to 0, and a term that sets both bits of one input is also 0.
- R2: Term t is configured by lit_cfg[t*44 +: 44]. Terms 0..63 are logic terms, and term t belongs to cluster t/4. Term 64 is oe_term[0], term 65 is oe_term[1], term 66 is arst_term and term 67 is apre_term.
- R3: The value of a cluster is the OR of its four terms.
- R4: Cluster c is steered by steer_cfg[3c +: 3]. Code 0 leaves the cluster unused. Codes 1, 2, 3 and 4 send it to macrocell c-2, c-1, c and c+1, in that order.
- R5: mc_sum[m] is the OR of every cluster steered to macrocell m. Macrocell m can reach clusters max(0,m-1) through min(15,m+2). Macrocell 0 therefore reaches clusters 0..2, macrocell 15 reaches 14..15, and a macrocell with four reachable clusters can collect 16 terms.
- R6: Codes 5..7 drive nothing. A code whose target macrocell would be below 0 or above 15 also drives nothing.
- R7: A cluster contributes to at most one macrocell.
- R8: Every output takes one clock to follow its inputs. An output holds its value while the inputs and the configuration hold theirs.
- R9: While rst_n is low at a rising clock edge, all outputs are cleared to 0 at that edge.
- R10: The four special terms drive oe_term, arst_term and apre_term directly. The steering code has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vec | input | 22 | Routed input signals |
| lit_cfg | input | 2992 | Literal selection, 44 bits per term, for 68 terms |
| steer_cfg | input | 48 | Steering code, 3 bits per cluster |
| mc_sum | output | 16 | Registered macrocell sums |
| oe_term | output | 2 | Registered output-enable terms |
| arst_term | output | 1 | Registered asynchronous-reset term |
| apre_term | output | 1 | Registered asynchronous-preset term |

## Verification
The first pattern is a polarity sweep that gives each cluster a single true or complemented literal. It separates the true, complement, empty and contradictory literal cases. A second pattern puts a lone term at a random position inside each cluster, which exposes term-to-cluster indexing errors. A third pattern steers every cluster in one macrocell's window onto that macrocell, for each of the 16 macrocells, which checks the offset codes and the clipped edges at both ends. Illegal-code patterns and long random configurations then show whether a cluster ever leaks into a wrong macrocell or into two at once.

// File: rtl/pterm_alloc.sv
module pterm_alloc #(
  parameter int N_IN   = 22,
  parameter int N_CLU  = 16,
  parameter int TPC    = 4,
  parameter int WIN_LO = 1,
  parameter int WIN_HI = 2,
  parameter int SEL_W  = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_IN-1:0]                     in_vec,
  input  logic [(N_CLU*TPC+4)*2*N_IN-1:0]     lit_cfg,
  input  logic [N_CLU*SEL_W-1:0]              steer_cfg,
  output logic [N_CLU-1:0]                    mc_sum,
  output logic [1:0]                          oe_term,
  output logic                                arst_term,
  output logic                                apre_term
);
  localparam int N_LT   = N_CLU * TPC;
  localparam int N_TERM = N_LT + 4;
  localparam int LW     = 2 * N_IN;

  logic [N_TERM-1:0] term;
  logic [N_CLU-1:0]  clu;
  logic [N_CLU-1:0]  sum_d;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LW-1:0] cfg;
    logic          hit;
    assign cfg = lit_cfg[t*LW +: LW];
    always_comb begin
      hit = 1'b1;
      for (int j = 0; j < N_IN; j++) begin
        if (cfg[2*j]   && !in_vec[j]) hit = 1'b0;
        if (cfg[2*j+1] &&  in_vec[j]) hit = 1'b0;
      end
    end
    assign term[t] = hit & (|cfg);
  end

  for (genvar c = 0; c < N_CLU; c++) begin : g_clu
    assign clu[c] = |term[c*TPC +: TPC];
  end

  for (genvar m = 0; m < N_CLU; m++) begin : g_mc
    logic [N_CLU-1:0] pick;
    for (genvar c = 0; c < N_CLU; c++) begin : g_src
      if (c >= m - WIN_LO && c <= m + WIN_HI) begin : g_on
        assign pick[c] = clu[c] &
          (steer_cfg[c*SEL_W +: SEL_W] == SEL_W'(m - c + WIN_HI + 1));
      end else begin : g_off
        assign pick[c] = 1'b0;
      end
    end
    assign sum_d[m] = |pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_sum    <= '0;
      oe_term   <= '0;
      arst_term <= 1'b0;
      apre_term <= 1'b0;
    end else begin
      mc_sum    <= sum_d;
      oe_term   <= term[N_LT +: 2];
      arst_term <= term[N_LT+2];
      apre_term <= term[N_LT+3];
    end
  end
endmodule

// File: rtl/pterm_alloc_chk.sv
module pterm_alloc_chk #(
  parameter int N_IN   = 22,
  parameter int N_CLU  = 16,
  parameter int TPC    = 4,
  parameter int WIN_LO = 1,
  parameter int WIN_HI = 2,
  parameter int SEL_W  = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [N_IN-1:0]                 in_vec,
  input logic [(N_CLU*TPC+4)*2*N_IN-1:0] lit_cfg,
  input logic [N_CLU*SEL_W-1:0]          steer_cfg,
  input logic [N_CLU-1:0]                mc_sum,
  input logic [1:0]                      oe_term,
  input logic                            arst_term,
  input logic                            apre_term
);
  localparam int N_LT = N_CLU * TPC;
  localparam int LW   = 2 * N_IN;

  function automatic int legal_count(input logic [N_CLU*SEL_W-1:0] s);
    int n;
    n = 0;
    for (int c = 0; c < N_CLU; c++) begin
      int k;
      int m;
      k = int'(s[c*SEL_W +: SEL_W]);
      m = c + k - WIN_HI - 1;
      if (k >= 1 && k <= WIN_LO + WIN_HI + 1 && m >= 0 && m < N_CLU) n++;
    end
    return n;
  endfunction

  logic [7:0] n_legal;
  assign n_legal = 8'(legal_count(steer_cfg));

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(mc_sum) <= int'($past(n_legal))));

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_legal == 8'd0) |=> (mc_sum == '0));

  // R10
  spc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_cfg[N_LT*LW +: 4*LW] == '0) |=> (oe_term == 2'b00 && !arst_term && !apre_term));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(in_vec) && $stable(lit_cfg) && $stable(steer_cfg))
    |=> ($stable(mc_sum) && $stable(oe_term) && $stable(arst_term) && $stable(apre_term)));
endmodule

bind pterm_alloc pterm_alloc_chk #(
  .N_IN(N_IN), .N_CLU(N_CLU), .TPC(TPC), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .lit_cfg(lit_cfg), .steer_cfg(steer_cfg),
  .mc_sum(mc_sum), .oe_term(oe_term), .arst_term(arst_term), .apre_term(apre_term)
);

// File: tb/pterm_alloc_bench.sv
`timescale 1ns/1ps
module pterm_alloc_bench;
  localparam int N_IN = 22, N_CLU = 16, TPC = 4, SEL_W = 3;
  localparam int N_LT = N_CLU*TPC, N_TERM = N_LT + 4, LW = 2*N_IN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0] in_vec = '0;
  logic [N_TERM*LW-1:0] lit_cfg = '0;
  logic [N_CLU*SEL_W-1:0] steer_cfg = '0;
  logic [N_CLU-1:0] mc_sum;
  logic [1:0] oe_term;
  logic arst_term, apre_term;

  logic [N_CLU-1:0] exp_sum = '0;
  logic [3:0] exp_spc = '0;
  int checks = 0, fails = 0, illegal_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pterm_alloc u_pterm_alloc (
    .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .lit_cfg(lit_cfg), .steer_cfg(steer_cfg),
    .mc_sum(mc_sum), .oe_term(oe_term), .arst_term(arst_term), .apre_term(apre_term));

  function automatic bit ref_term(int t);
    bit any = 0, r = 1;
    for (int j = 0; j < N_IN; j++) begin
      bit p = lit_cfg[t*LW + 2*j];
      bit n = lit_cfg[t*LW + 2*j + 1];
      if (p || n) any = 1;
      if (p && !in_vec[j]) r = 0;
      if (n && in_vec[j]) r = 0;
    end
    return any & r;
  endfunction

  task automatic refresh();
    exp_sum = '0;
    exp_spc = '0;
    if (rst_n) begin
      for (int c = 0; c < N_CLU; c++) begin
        bit cv = 0;
        int k = int'(steer_cfg[c*SEL_W +: SEL_W]);
        int m = c + k - 3;
        for (int q = 0; q < TPC; q++) cv |= ref_term(c*TPC + q);
        if (k >= 1 && k <= 4 && m >= 0 && m < N_CLU && cv) exp_sum[m] = 1'b1;
      end
      for (int s = 0; s < 4; s++) exp_spc[s] = ref_term(N_LT + s);
    end
  endtask

  task automatic tick(string tag);
    refresh();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (mc_sum !== exp_sum) begin
      fails++;
      $display("FAIL %s mc_sum got %h exp %h", tag, mc_sum, exp_sum);
    end
    checks++;
    if ({apre_term, arst_term, oe_term} !== exp_spc) begin
      fails++;
      $display("FAIL R10 (%s) specials got %b exp %b", tag, {apre_term, arst_term, oe_term}, exp_spc);
    end
  endtask

  function automatic logic [LW-1:0] rand_term();
    logic [LW-1:0] v = '0;
    int nl = $urandom_range(0, 2);
    for (int i = 0; i < nl; i++) v[2*$urandom_range(0, N_IN-1) + $urandom_range(0, 1)] = 1'b1;
    if ($urandom_range(0, 15) == 0) begin
      int j = $urandom_range(0, N_IN-1);
      v[2*j] = 1'b1;
      v[2*j+1] = 1'b1;
    end
    return v;
  endfunction

  task automatic rand_specials();
    for (int s = 0; s < 4; s++) lit_cfg[(N_LT+s)*LW +: LW] = rand_term();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run did not complete (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset clears outputs even with a busy configuration
    for (int t = 0; t < N_TERM; t++) lit_cfg[t*LW +: LW] = rand_term();
    for (int c = 0; c < N_CLU; c++) steer_cfg[c*SEL_W +: SEL_W] = 3'd3;
    in_vec = N_IN'($urandom);
    repeat (3) tick("R9");
    @(negedge clk);
    rst_n = 1'b1;

    // R4: all clusters unused leaves sums at zero
    steer_cfg = '0;
    repeat (6) begin in_vec = N_IN'($urandom); rand_specials(); tick("R4"); end

    // R1: single literal per cluster, true / complement polarity sweep
    lit_cfg = '0;
    for (int c = 0; c < N_CLU; c++) begin
      lit_cfg[(c*TPC)*LW + 2*c + (c % 2)] = 1'b1;
      steer_cfg[c*SEL_W +: SEL_W] = 3'd3;
    end
    lit_cfg[(5*TPC)*LW + 2*5 + 0] = 1'b1;
    lit_cfg[(6*TPC)*LW +: LW] = '0;
    repeat (20) begin in_vec = N_IN'($urandom); rand_specials(); tick("R1"); end

    // R2 R3: lone term at a random slot of its cluster
    repeat (30) begin
      lit_cfg = '0;
      for (int c = 0; c < N_CLU; c++) begin
        int q = $urandom_range(0, TPC-1);
        lit_cfg[(c*TPC+q)*LW + 2*$urandom_range(0, N_IN-1) + $urandom_range(0, 1)] = 1'b1;
      end
      rand_specials();
      in_vec = N_IN'($urandom);
      tick("R3");
    end

    // R5: every reachable cluster piled onto one macrocell
    for (int m = 0; m < N_CLU; m++) begin
      steer_cfg = '0;
      for (int c = 0; c < N_CLU; c++)
        if (c >= m - 1 && c <= m + 2) steer_cfg[c*SEL_W +: SEL_W] = SEL_W'(m - c + 3);
      repeat (4) begin
        for (int t = 0; t < N_LT; t++) lit_cfg[t*LW +: LW] = rand_term();
        rand_specials();
        in_vec = N_IN'($urandom);
        tick("R5");
      end
    end

    // R6: illegal codes and off-edge targets drive nothing
    repeat (20) begin
      for (int c = 0; c < N_CLU; c++) begin
        logic [2:0] k = 3'($urandom_range(5, 7));
        if (c == 0 && $urandom_range(0, 1) == 1) k = 3'($urandom_range(1, 2));
        if (c == 1 && $urandom_range(0, 1) == 1) k = 3'd1;
        if (c == 15 && $urandom_range(0, 1) == 1) k = 3'd4;
        steer_cfg[c*SEL_W +: SEL_W] = k;
        illegal_seen++;
      end
      for (int t = 0; t < N_LT; t++) lit_cfg[t*LW +: LW] = rand_term();
      in_vec = N_IN'($urandom);
      tick("R6");
    end
    $display("note: %0d illegal steering codes applied", illegal_seen);

    // R7 R8: random configurations, held inputs in between
    repeat (1500) begin
      for (int t = 0; t < N_TERM; t++) lit_cfg[t*LW +: LW] = rand_term();
      for (int c = 0; c < N_CLU; c++) steer_cfg[c*SEL_W +: SEL_W] = 3'($urandom_range(0, 7));
      in_vec = N_IN'($urandom);
      tick("R7");
      if ($urandom_range(0, 3) == 0) tick("R8");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule